// File: doc/BRIEF.md
# Accelerator Kernel Control FSM

This block is the host-facing control plane of a compute accelerator. The host talks to it through a simple register port with separate write and read strobes. A control register carries a start request and a reset request. Four configuration words are forwarded to the processor as address/value strobes. A four-state sequencer (IDLE, INIT, RUN, DONE) takes the processor through a timed reset, follows the processor's busy flag through execution, and holds a done indication until the host acknowledges it by reading status.

While the processor reset output is asserted, an optional drain stage keeps the memory-response ready lines high toward memory. In the same period it forces the response-valid and request-valid lines toward the processor side low, so that stale traffic is absorbed instead of reaching a processor that is being reset. With the drain disabled by parameter, the lines pass straight through.

Host address 0 is the control/status register. Host addresses 1 to 4 are the configuration words: 1 is the start-address low word, 2 the start-address high word, 3 argument 0 and 4 argument 1. Writes to any other address are ignored.

Top module: `accel_ctrl_fsm`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `proc_rst` stays high for exactly RST_CYCLES clock cycles and then falls. A status read then returns 0b100.
- R2: A write to host address 0 with bit 0 set and bit 4 clear, accepted in IDLE after the processor reset has been released, enters INIT. It asserts `proc_rst` for exactly RST_CYCLES cycles, and status reads 0b001 while the block is in INIT or RUN.
- R3: A write to address 0 with bit 4 set returns the block to IDLE from any state and asserts `proc_rst` for exactly RST_CYCLES cycles. When bits 0 and 4 are written together, the start is not taken.
- R4: INIT moves to RUN only when `proc_busy` is high after `proc_rst` has fallen. A busy pulse seen while `proc_rst` is still high has no effect.
- R5: In RUN, a low `proc_busy` moves the block to DONE at the next edge. Status then reads 0b010.
- R6: DONE holds until a read of host address 0. That read returns 0b010, and the next status read returns 0b100 (IDLE).
- R7: A write to host address 1, 2, 3 or 4 made in IDLE produces, one cycle later, a single-cycle `cfg_wr_valid` carrying that address and data. Writes to other addresses, or writes made outside IDLE, produce no strobe.
- R8: A start request made outside IDLE, or made in IDLE while `proc_rst` is still high, is ignored.
- R9: With DRAIN_EN=1 and `proc_rst` high, every `mem_rsp_ready_o` bit is 1 and every `mem_rsp_valid_o` and `mem_req_valid_o` bit is 0. In all other cases each of these outputs equals its corresponding input.
- R10: Status bits are start (bit 0, INIT or RUN), done (bit 1, DONE) and idle (bit 2, IDLE). The idle bit is set only in IDLE. A read of any address other than 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_valid | input | 1 | Host write strobe |
| host_wr_addr | input | HOST_AW | Host write address |
| host_wr_data | input | DATA_W | Host write data |
| host_rd_valid | input | 1 | Host read strobe |
| host_rd_addr | input | HOST_AW | Host read address |
| host_rd_data | output | DATA_W | Read data, valid the cycle after the strobe |
| proc_rst | output | 1 | Processor reset |
| proc_busy | input | 1 | Processor busy flag |
| cfg_wr_valid | output | 1 | Configuration write strobe to the processor |
| cfg_wr_addr | output | CFG_AW | Configuration word address |
| cfg_wr_data | output | DATA_W | Configuration word value |
| mem_rsp_valid_i | input | NUM_PORTS | Response valid from memory |
| mem_rsp_valid_o | output | NUM_PORTS | Response valid to the processor |
| mem_rsp_ready_i | input | NUM_PORTS | Response ready from the processor |
| mem_rsp_ready_o | output | NUM_PORTS | Response ready to memory |
| mem_req_valid_i | input | NUM_PORTS | Request valid from the processor |
| mem_req_valid_o | output | NUM_PORTS | Request valid to memory |

## Verification
Host reads, configuration strobes and state changes are all due one clock edge after the strobe that causes them. `proc_rst` rises at the same edge that accepts a start or reset request and stays high for RST_CYCLES edges. The drain outputs follow their inputs combinationally. The bench drives every input on the falling edge and samples on the next falling edge, so each registered result is read exactly one edge after its cause. Reset windows are measured by counting the consecutive falling-edge samples in which `proc_rst` is high. The drain stage is swept over all input combinations, both during reset and after it.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } run_state_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_RESET_BIT = 4;
  localparam int CFG_ADDR_FIRST = 1;
  localparam int CFG_ADDR_LAST  = 4;
  localparam int STAT_START_BIT = 0;
  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_IDLE_BIT  = 2;
  localparam int STAT_W         = 3;
endpackage

// File: rtl/acc_rst_timer.sv
module acc_rst_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic rst_active
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? CNT_INIT : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_active = (cnt_q != '0);
endmodule

// File: rtl/acc_host_decode.sv
module acc_host_decode
  import accel_ctrl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HOST_AW = 4,
  parameter int CFG_AW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_valid,
  input  logic [HOST_AW-1:0] rd_addr,
  input  run_state_e         state,
  output logic               start_req,
  output logic               soft_rst_req,
  output logic               ack_req,
  output logic [DATA_W-1:0]  rd_data,
  output logic               cfg_valid,
  output logic [CFG_AW-1:0]  cfg_addr,
  output logic [DATA_W-1:0]  cfg_data
);
  localparam logic [HOST_AW-1:0] CTRL_ADDR = '0;
  localparam logic [HOST_AW-1:0] CFG_LO    = HOST_AW'(CFG_ADDR_FIRST);
  localparam logic [HOST_AW-1:0] CFG_HI    = HOST_AW'(CFG_ADDR_LAST);

  logic              ctrl_hit;
  logic              cfg_hit;
  logic [STAT_W-1:0] status;
  logic [DATA_W-1:0] rd_data_d;

  always_comb begin
    ctrl_hit     = wr_valid && (wr_addr == CTRL_ADDR);
    soft_rst_req = ctrl_hit && wr_data[CTRL_RESET_BIT];
    start_req    = ctrl_hit && wr_data[CTRL_START_BIT] && !wr_data[CTRL_RESET_BIT];
    ack_req      = rd_valid && (rd_addr == CTRL_ADDR);
    cfg_hit      = wr_valid && (wr_addr >= CFG_LO) && (wr_addr <= CFG_HI) &&
                   (state == ST_IDLE);
    status                 = '0;
    status[STAT_START_BIT] = (state == ST_INIT) || (state == ST_RUN);
    status[STAT_DONE_BIT]  = (state == ST_DONE);
    status[STAT_IDLE_BIT]  = (state == ST_IDLE);
    rd_data_d = ack_req ? DATA_W'(status) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= cfg_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_data <= '0;
    end else if (cfg_hit) begin
      cfg_addr <= CFG_AW'(wr_addr);
      cfg_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_valid) begin
      rd_data <= rd_data_d;
    end
  end
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import accel_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       soft_rst_req,
  input  logic       ack_req,
  input  logic       rst_active,
  input  logic       busy,
  output run_state_e state,
  output logic       timer_load
);
  run_state_e state_q;
  run_state_e state_d;
  logic       start_take;

  always_comb begin
    start_take = (state_q == ST_IDLE) && start_req && !rst_active;
    timer_load = soft_rst_req || start_take;
    state_d    = state_q;
    if (soft_rst_req) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_take)            state_d = ST_INIT;
        ST_INIT: if (!rst_active && busy)   state_d = ST_RUN;
        ST_RUN:  if (!busy)                 state_d = ST_DONE;
        ST_DONE: if (ack_req)               state_d = ST_IDLE;
        default:                            state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/acc_mem_drain.sv
module acc_mem_drain #(
  parameter int NUM_PORTS = 2,
  parameter bit DRAIN_EN  = 1'b1
) (
  input  logic                 hold,
  input  logic [NUM_PORTS-1:0] rsp_valid_i,
  output logic [NUM_PORTS-1:0] rsp_valid_o,
  input  logic [NUM_PORTS-1:0] rsp_ready_i,
  output logic [NUM_PORTS-1:0] rsp_ready_o,
  input  logic [NUM_PORTS-1:0] req_valid_i,
  output logic [NUM_PORTS-1:0] req_valid_o
);
  generate
    if (DRAIN_EN) begin : g_drain
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        assign rsp_ready_o[p] = hold ? 1'b1 : rsp_ready_i[p];
        assign rsp_valid_o[p] = hold ? 1'b0 : rsp_valid_i[p];
        assign req_valid_o[p] = hold ? 1'b0 : req_valid_i[p];
      end
    end else begin : g_pass
      logic unused_hold;
      assign unused_hold = hold;
      assign rsp_ready_o = rsp_ready_i;
      assign rsp_valid_o = rsp_valid_i;
      assign req_valid_o = req_valid_i;
    end
  endgenerate
endmodule

// File: rtl/accel_ctrl_fsm.sv
module accel_ctrl_fsm
  import accel_ctrl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int HOST_AW    = 4,
  parameter int CFG_AW     = 4,
  parameter int RST_CYCLES = 16,
  parameter int NUM_PORTS  = 2,
  parameter bit DRAIN_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr_valid,
  input  logic [HOST_AW-1:0]   host_wr_addr,
  input  logic [DATA_W-1:0]    host_wr_data,
  input  logic                 host_rd_valid,
  input  logic [HOST_AW-1:0]   host_rd_addr,
  output logic [DATA_W-1:0]    host_rd_data,
  output logic                 proc_rst,
  input  logic                 proc_busy,
  output logic                 cfg_wr_valid,
  output logic [CFG_AW-1:0]    cfg_wr_addr,
  output logic [DATA_W-1:0]    cfg_wr_data,
  input  logic [NUM_PORTS-1:0] mem_rsp_valid_i,
  output logic [NUM_PORTS-1:0] mem_rsp_valid_o,
  input  logic [NUM_PORTS-1:0] mem_rsp_ready_i,
  output logic [NUM_PORTS-1:0] mem_rsp_ready_o,
  input  logic [NUM_PORTS-1:0] mem_req_valid_i,
  output logic [NUM_PORTS-1:0] mem_req_valid_o
);
  run_state_e run_state;
  logic       start_req;
  logic       soft_rst_req;
  logic       ack_req;
  logic       timer_load;
  logic       rst_active;

  acc_host_decode #(
    .DATA_W (DATA_W),
    .HOST_AW(HOST_AW),
    .CFG_AW (CFG_AW)
  ) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (host_wr_valid),
    .wr_addr     (host_wr_addr),
    .wr_data     (host_wr_data),
    .rd_valid    (host_rd_valid),
    .rd_addr     (host_rd_addr),
    .state       (run_state),
    .start_req   (start_req),
    .soft_rst_req(soft_rst_req),
    .ack_req     (ack_req),
    .rd_data     (host_rd_data),
    .cfg_valid   (cfg_wr_valid),
    .cfg_addr    (cfg_wr_addr),
    .cfg_data    (cfg_wr_data)
  );

  acc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .soft_rst_req(soft_rst_req),
    .ack_req     (ack_req),
    .rst_active  (rst_active),
    .busy        (proc_busy),
    .state       (run_state),
    .timer_load  (timer_load)
  );

  acc_rst_timer #(
    .CYCLES(RST_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (timer_load),
    .rst_active(rst_active)
  );

  assign proc_rst = rst_active;

  acc_mem_drain #(
    .NUM_PORTS(NUM_PORTS),
    .DRAIN_EN (DRAIN_EN)
  ) u_drain (
    .hold       (rst_active),
    .rsp_valid_i(mem_rsp_valid_i),
    .rsp_valid_o(mem_rsp_valid_o),
    .rsp_ready_i(mem_rsp_ready_i),
    .rsp_ready_o(mem_rsp_ready_o),
    .req_valid_i(mem_req_valid_i),
    .req_valid_o(mem_req_valid_o)
  );
endmodule

// File: rtl/acc_ctrl_checker.sv
module acc_ctrl_checker
  import accel_ctrl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HOST_AW   = 4,
  parameter int CFG_AW    = 4,
  parameter int NUM_PORTS = 2,
  parameter bit DRAIN_EN  = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_wr_valid,
  input logic [HOST_AW-1:0]   host_wr_addr,
  input logic [DATA_W-1:0]    host_wr_data,
  input logic                 host_rd_valid,
  input logic [HOST_AW-1:0]   host_rd_addr,
  input logic                 proc_rst,
  input logic                 proc_busy,
  input logic                 cfg_wr_valid,
  input logic [CFG_AW-1:0]    cfg_wr_addr,
  input logic [NUM_PORTS-1:0] mem_rsp_valid_o,
  input logic [NUM_PORTS-1:0] mem_rsp_ready_o,
  input logic [NUM_PORTS-1:0] mem_req_valid_o,
  input run_state_e           state
);
  logic soft_rst_wr;
  logic status_rd;
  assign soft_rst_wr = host_wr_valid && (host_wr_addr == '0) && host_wr_data[CTRL_RESET_BIT];
  assign status_rd   = host_rd_valid && (host_rd_addr == '0);

  // R7: a strobe only follows an IDLE write to a configuration address
  assert_cfg_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid |-> ($past(state) == ST_IDLE) && $past(host_wr_valid) &&
                     (cfg_wr_addr >= CFG_AW'(CFG_ADDR_FIRST)) &&
                     (cfg_wr_addr <= CFG_AW'(CFG_ADDR_LAST)));

  // R3: reset request lands in IDLE with the processor held in reset
  assert_reset_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_wr |=> (state == ST_IDLE) && proc_rst);

  // R2: entering INIT always comes with processor reset asserted
  assert_init_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT && $past(state) == ST_IDLE) |-> proc_rst);

  // R4: RUN is entered only on busy after reset release
  assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_INIT) |-> ($past(proc_busy) && !$past(proc_rst)));

  // R5: busy low in RUN finishes the run
  assert_run_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !proc_busy && !soft_rst_wr) |=> (state == ST_DONE));

  // R6: DONE is held until the status read
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !status_rd && !soft_rst_wr) |=> (state == ST_DONE));

  // R9: drain blocks processor-side valids while reset is asserted
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (DRAIN_EN && proc_rst) |-> (&mem_rsp_ready_o) && (mem_rsp_valid_o == '0) &&
                               (mem_req_valid_o == '0));
endmodule

bind accel_ctrl_fsm acc_ctrl_checker #(
  .DATA_W   (DATA_W),
  .HOST_AW  (HOST_AW),
  .CFG_AW   (CFG_AW),
  .NUM_PORTS(NUM_PORTS),
  .DRAIN_EN (DRAIN_EN)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr_valid  (host_wr_valid),
  .host_wr_addr   (host_wr_addr),
  .host_wr_data   (host_wr_data),
  .host_rd_valid  (host_rd_valid),
  .host_rd_addr   (host_rd_addr),
  .proc_rst       (proc_rst),
  .proc_busy      (proc_busy),
  .cfg_wr_valid   (cfg_wr_valid),
  .cfg_wr_addr    (cfg_wr_addr),
  .mem_rsp_valid_o(mem_rsp_valid_o),
  .mem_rsp_ready_o(mem_rsp_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .state          (run_state)
);

// File: tb/accel_ctrl_fsm_bench.sv
module accel_ctrl_fsm_bench;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NRST = 4;
  localparam int NP = 2;

  logic clk;
  logic rst_n;
  logic hwv;
  logic [AW-1:0] hwa;
  logic [DW-1:0] hwd;
  logic hrv;
  logic [AW-1:0] hra;
  logic [DW-1:0] hrd, hrd_nd;
  logic prst, prst_nd;
  logic busy;
  logic cfgv, cfgv_nd;
  logic [AW-1:0] cfga, cfga_nd;
  logic [DW-1:0] cfgd, cfgd_nd;
  logic [NP-1:0] rvi, rri, qvi;
  logic [NP-1:0] rvo, rro, qvo, rvo_nd, rro_nd, qvo_nd;

  int nchk = 0;
  int nfail = 0;

  accel_ctrl_fsm #(.DATA_W(DW), .HOST_AW(AW), .CFG_AW(AW), .RST_CYCLES(NRST),
                   .NUM_PORTS(NP), .DRAIN_EN(1'b1)) u_accel_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .host_wr_valid(hwv), .host_wr_addr(hwa), .host_wr_data(hwd),
    .host_rd_valid(hrv), .host_rd_addr(hra), .host_rd_data(hrd), .proc_rst(prst),
    .proc_busy(busy), .cfg_wr_valid(cfgv), .cfg_wr_addr(cfga), .cfg_wr_data(cfgd),
    .mem_rsp_valid_i(rvi), .mem_rsp_valid_o(rvo), .mem_rsp_ready_i(rri),
    .mem_rsp_ready_o(rro), .mem_req_valid_i(qvi), .mem_req_valid_o(qvo));

  accel_ctrl_fsm #(.DATA_W(DW), .HOST_AW(AW), .CFG_AW(AW), .RST_CYCLES(NRST),
                   .NUM_PORTS(NP), .DRAIN_EN(1'b0)) u_accel_ctrl_fsm_nd (
    .clk(clk), .rst_n(rst_n), .host_wr_valid(hwv), .host_wr_addr(hwa), .host_wr_data(hwd),
    .host_rd_valid(hrv), .host_rd_addr(hra), .host_rd_data(hrd_nd), .proc_rst(prst_nd),
    .proc_busy(busy), .cfg_wr_valid(cfgv_nd), .cfg_wr_addr(cfga_nd), .cfg_wr_data(cfgd_nd),
    .mem_rsp_valid_i(rvi), .mem_rsp_valid_o(rvo_nd), .mem_rsp_ready_i(rri),
    .mem_rsp_ready_o(rro_nd), .mem_req_valid_i(qvi), .mem_req_valid_o(qvo_nd));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hwv = 1'b1; hwa = a; hwd = d;
    @(negedge clk);
    hwv = 1'b0;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    hrv = 1'b1; hra = a;
    @(negedge clk);
    hrv = 1'b0;
    d = hrd;
  endtask

  // counts falling-edge samples with proc_rst high, starting now
  task automatic rst_len(output int n);
    n = 0;
    while (prst && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic drain_sweep(input logic hold_exp, input string tag);
    for (int p = 0; p < 64; p++) begin
      rvi = p[1:0]; rri = p[3:2]; qvi = p[5:4];
      #1;
      if (hold_exp) begin
        chk({tag, " R9 drain ready"}, 32'(rro), 32'(2'b11));
        chk({tag, " R9 drain rsp valid"}, 32'(rvo), 32'd0);
        chk({tag, " R9 drain req valid"}, 32'(qvo), 32'd0);
      end else begin
        chk({tag, " R9 pass ready"}, 32'(rro), 32'(p[3:2]));
        chk({tag, " R9 pass rsp valid"}, 32'(rvo), 32'(p[1:0]));
        chk({tag, " R9 pass req valid"}, 32'(qvo), 32'(p[5:4]));
      end
      chk({tag, " R9 nodrain ready"}, 32'(rro_nd), 32'(p[3:2]));
      chk({tag, " R9 nodrain rsp"}, 32'(rvo_nd), 32'(p[1:0]));
      chk({tag, " R9 nodrain req"}, 32'(qvo_nd), 32'(p[5:4]));
    end
    rvi = '0; rri = '0; qvi = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] d;
    rst_n = 1'b0; hwv = 1'b0; hwa = '0; hwd = '0; hrv = 1'b0; hra = '0;
    busy = 1'b0; rvi = '0; rri = '0; qvi = '0;
    repeat (3) @(negedge clk);
    drain_sweep(1'b1, "in reset");
    rst_n = 1'b1;
    // R1: power-up processor reset window
    rst_len(n);
    chk("R1 reset window", 32'(n), 32'(NRST));
    host_rd('0, d);
    chk("R1 status after reset", d, 32'h4);
    chk("R7 no strobe after reset", 32'(cfgv), 32'd0);
    drain_sweep(1'b0, "released");

    // control-bit sweep: R2, R3
    for (int v = 0; v < 4; v++) begin
      logic [DW-1:0] cw;
      cw = {27'd0, v[1], 3'd0, v[0]};
      host_wr('0, cw);
      rst_len(n);
      if (v[1]) begin
        chk("R3 reset window", 32'(n), 32'(NRST));
        host_rd('0, d);
        chk("R3 reset wins, idle", d, 32'h4);
      end else if (v[0]) begin
        chk("R2 init reset window", 32'(n), 32'(NRST));
        host_rd('0, d);
        chk("R2 status in INIT", d, 32'h1);
        host_wr('0, 32'h10);
        rst_len(n);
        chk("R3 reset from INIT window", 32'(n), 32'(NRST));
        host_rd('0, d);
        chk("R3 status after reset from INIT", d, 32'h4);
      end else begin
        chk("R8 no-op write keeps reset low", 32'(n), 32'd0);
        host_rd('0, d);
        chk("R10 no-op write stays idle", d, 32'h4);
      end
    end

    // R8: start while reset counter runs in IDLE is ignored
    host_wr('0, 32'h10);
    host_wr('0, 32'h1);
    rst_len(n);
    repeat (2) @(negedge clk);
    chk("R8 start during reset ignored: rst", 32'(prst), 32'd0);
    host_rd('0, d);
    chk("R8 start during reset ignored: status", d, 32'h4);

    // R4: busy pulse during reset is ignored
    host_wr('0, 32'h1);
    busy = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    rst_len(n);
    repeat (3) @(negedge clk);
    host_rd('0, d);
    chk("R4 busy in reset ignored", d, 32'h1);
    // now busy -> RUN
    busy = 1'b1;
    repeat (2) @(negedge clk);
    host_wr('0, 32'h1);
    chk("R8 start in RUN no reset", 32'(prst), 32'd0);
    host_wr(4'd2, 32'hDEAD);
    chk("R7 cfg write in RUN ignored", 32'(cfgv), 32'd0);
    host_rd('0, d);
    chk("R10 status while running", d, 32'h1);
    busy = 1'b0;
    repeat (6) @(negedge clk);
    host_rd(4'd3, d);
    chk("R10 non-status read is zero", d, 32'h0);
    host_rd('0, d);
    chk("R5 R6 done reported and held", d, 32'h2);
    host_rd('0, d);
    chk("R6 back to idle after ack", d, 32'h4);

    // R2 R4 R5: run with busy asserted throughout reset
    host_wr('0, 32'h1);
    busy = 1'b1;
    rst_len(n);
    chk("R2 run window", 32'(n), 32'(NRST));
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    host_rd('0, d);
    chk("R5 done after busy fall", d, 32'h2);
    host_rd('0, d);
    chk("R6 idle after ack", d, 32'h4);

    // R7: configuration address sweep in IDLE
    for (int a = 0; a < 16; a++) begin
      logic exp_v;
      exp_v = (a >= 1) && (a <= 4);
      host_wr(AW'(a), 32'hA500 + 32'(a));
      chk("R7 cfg strobe", 32'(cfgv), 32'(exp_v));
      if (exp_v) begin
        chk("R7 cfg addr", 32'(cfga), 32'(a));
        chk("R7 cfg data", cfgd, 32'hA500 + 32'(a));
      end
      @(negedge clk);
      chk("R7 strobe single cycle", 32'(cfgv), 32'd0);
    end
    host_rd('0, d);
    chk("R10 idle after cfg sweep", d, 32'h4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule